// File: doc/BRIEF.md
# Vectored Interrupt Receive Latch

This block sits beside a processor core and takes in vectored interrupts that arrive as levels on a set of numbered lines. When it is free and at least one line is high, it takes the line with the lowest number. It sets a busy flag in its status register and records a three-word payload that names the line. It also loads the vectored trap code, raises a hard-interrupt request toward the core, and wakes the core if the core was halted.

While a vector is held, the latch does not accept another one. Lines that are still high wait until the latch is free. The captured line's level acts as the acknowledge: when the interrupt source drops that line, the busy flag clears and the hard-interrupt request goes away. The payload words and the trap code are kept until the next capture. The latch also reports a priority of 16 while its request is raised, which puts the vectored interrupt above every level interrupt from 1 to 15.

Top module: `vec_irq_latch`

## Requirements
- R1: During and after synchronous reset, `status_q`, all three payload words, `trap_code`, `hard_req`, `irq_prio` and `halted` are zero.
- R2: If status bit 5 is clear and any line of `irq_lvl` is high at a clock edge, then after that edge status bit 5 is 1, `hard_req` is 1 and `trap_code` is 9'h060.
- R3: On a capture, `vec_word0` becomes (5'h1F << 6) | line, with the line number in bits 5:0, ones in bits 10:6 and zeros above. `vec_word1` and `vec_word2` become zero.
- R4: When several lines are high at a capture edge, the lowest-numbered line is the one recorded.
- R5: While status bit 5 is set, changes on the other lines leave the payload, the trap code and the busy flag unchanged. A line that is still high is captured at the first edge after the latch is free.
- R6: If status bit 5 is set and the captured line is low at a clock edge, then after that edge bit 5 and `hard_req` are 0. The payload words and `trap_code` keep their values, and no capture happens at that same edge.
- R7: A capture clears `halted`. Otherwise `halt_set` high at an edge sets `halted`, and `halted` holds its value. A capture wins over `halt_set` at the same edge.
- R8: `irq_prio` is 16 while `hard_req` is 1 and 0 otherwise. Every status bit other than bit 5 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl | input | NUM_LINES | Vectored interrupt levels, one per line |
| halt_set | input | 1 | Core enters halted state |
| status_q | output | 8 | Status register, bit 5 = busy |
| vec_word0 | output | WORD_W | Payload word 0 (tag and line number) |
| vec_word1 | output | WORD_W | Payload word 1 |
| vec_word2 | output | WORD_W | Payload word 2 |
| trap_code | output | 9 | Held trap code |
| hard_req | output | 1 | Hard-interrupt request to the core |
| irq_prio | output | 5 | Priority of the pending request |
| halted | output | 1 | Core halted indication |

## Verification
A busy flag stuck or dropped in error shows up as a second capture that overwrites `vec_word0`, or as `hard_req` staying high, in the cycle right after the edge where the line changed. A wrong line choice or a wrong tag field shows up in `vec_word0` one cycle after the capture edge. A missed wake shows up on `halted` in that same cycle. The bench compares every output after every edge against a model of its own, so a divergence in state is reported within one clock.

// File: rtl/vrl_pkg.sv
package vrl_pkg;

    localparam int WORD_W       = 64;
    localparam int STATUS_W     = 8;
    localparam int BUSY_BIT     = 5;
    localparam int LINE_FIELD_W = 6;
    localparam int TAG_W        = 5;
    localparam int TRAP_W       = 9;
    localparam int PRIO_W       = 5;

    localparam logic [TAG_W-1:0]  VEC_TAG   = 5'h1F;
    localparam logic [TRAP_W-1:0] TRAP_VEC  = 9'h060;
    localparam logic [PRIO_W-1:0] PRIO_VEC  = 5'd16;

    typedef logic [WORD_W-1:0] vword_t;

    typedef struct packed {
        vword_t w0;
        vword_t w1;
        vword_t w2;
    } vec_payload_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } latch_state_e;

    // Word 0 layout: tag in bits 10:6, line number in bits 5:0.
    function automatic vword_t make_word0(input logic [LINE_FIELD_W-1:0] line);
        vword_t w;
        w = '0;
        w[LINE_FIELD_W-1:0]         = line;
        w[LINE_FIELD_W +: TAG_W]    = VEC_TAG;
        return w;
    endfunction

    function automatic vec_payload_t make_payload(input logic [LINE_FIELD_W-1:0] line);
        vec_payload_t p;
        p.w0 = make_word0(line);
        p.w1 = '0;
        p.w2 = '0;
        return p;
    endfunction

endpackage

// File: rtl/vrl_line_pick.sv
module vrl_line_pick #(
    parameter int NUM_LINES = 8,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] lvl,
    output logic                 any,
    output logic [LINE_W-1:0]    idx
);
    logic [NUM_LINES-1:0] lowest_oh;

    // Isolate the lowest set line.
    assign lowest_oh = lvl & (~lvl + NUM_LINES'(1));
    assign any       = |lvl;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (lowest_oh[i]) idx = LINE_W'(i);
        end
    end
endmodule

// File: rtl/vrl_payload.sv
module vrl_payload
    import vrl_pkg::*;
#(
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] line,
    output vec_payload_t      pay_q
);
    vec_payload_t pay_d;

    always_comb begin
        pay_d = make_payload(LINE_FIELD_W'(line));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pay_q <= '0;
        end else if (load) begin
            pay_q <= pay_d;
        end
    end
endmodule

// File: rtl/vrl_ctrl.sv
module vrl_ctrl
    import vrl_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lvl,
    input  logic                 pick_any,
    input  logic [LINE_W-1:0]    pick_idx,
    input  logic                 halt_set,
    output logic                 load,
    output logic [LINE_W-1:0]    line_q,
    output latch_state_e         state_q,
    output logic [TRAP_W-1:0]    trap_q,
    output logic                 req_q,
    output logic                 halted_q
);
    logic held_lvl;
    logic release_now;

    assign held_lvl    = lvl[line_q];
    assign load        = (state_q == ST_IDLE) && pick_any;
    assign release_now = (state_q == ST_HELD) && !held_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            line_q   <= '0;
            trap_q   <= '0;
            req_q    <= 1'b0;
            halted_q <= 1'b0;
        end else begin
            if (load) begin
                state_q <= ST_HELD;
                line_q  <= pick_idx;
                trap_q  <= TRAP_VEC;
                req_q   <= 1'b1;
            end else if (release_now) begin
                state_q <= ST_IDLE;
                req_q   <= 1'b0;
            end
            if (load) begin
                halted_q <= 1'b0;
            end else if (halt_set) begin
                halted_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vec_irq_latch.sv
module vec_irq_latch
    import vrl_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lvl,
    input  logic                 halt_set,
    output logic [STATUS_W-1:0]  status_q,
    output logic [WORD_W-1:0]    vec_word0,
    output logic [WORD_W-1:0]    vec_word1,
    output logic [WORD_W-1:0]    vec_word2,
    output logic [TRAP_W-1:0]    trap_code,
    output logic                 hard_req,
    output logic [PRIO_W-1:0]    irq_prio,
    output logic                 halted
);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic              pick_any;
    logic [LINE_W-1:0] pick_idx;
    logic              load;
    logic [LINE_W-1:0] line_q;
    latch_state_e      state_q;
    vec_payload_t      pay_q;

    vrl_line_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .lvl (irq_lvl),
        .any (pick_any),
        .idx (pick_idx)
    );

    vrl_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .lvl      (irq_lvl),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .halt_set (halt_set),
        .load     (load),
        .line_q   (line_q),
        .state_q  (state_q),
        .trap_q   (trap_code),
        .req_q    (hard_req),
        .halted_q (halted)
    );

    vrl_payload #(.LINE_W(LINE_W)) u_pay (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .line  (pick_idx),
        .pay_q (pay_q)
    );

    always_comb begin
        status_q           = '0;
        status_q[BUSY_BIT] = (state_q == ST_HELD);
    end

    assign vec_word0 = pay_q.w0;
    assign vec_word1 = pay_q.w1;
    assign vec_word2 = pay_q.w2;
    assign irq_prio  = hard_req ? PRIO_VEC : '0;
endmodule

// File: rtl/vrl_checker.sv
module vrl_checker
    import vrl_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] irq_lvl,
    input logic                 halt_set,
    input logic [STATUS_W-1:0]  status_q,
    input logic [WORD_W-1:0]    vec_word0,
    input logic [WORD_W-1:0]    vec_word1,
    input logic [WORD_W-1:0]    vec_word2,
    input logic [TRAP_W-1:0]    trap_code,
    input logic                 hard_req,
    input logic [PRIO_W-1:0]    irq_prio,
    input logic                 halted
);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic              busy;
    logic [LINE_W-1:0] cur_idx;
    logic              cur_lvl;

    assign busy    = status_q[BUSY_BIT];
    assign cur_idx = vec_word0[LINE_W-1:0];
    assign cur_lvl = irq_lvl[cur_idx];

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (!busy && |irq_lvl) |=> (busy && hard_req && trap_code == TRAP_VEC));

    a_r3_word_shape: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (vec_word0 == make_word0(LINE_FIELD_W'(cur_idx))
                         && vec_word1 == '0 && vec_word2 == '0));

    a_r5_held_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_lvl) |=> (busy && $stable(vec_word0) && $stable(trap_code)));

    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (busy && !cur_lvl) |=> (!busy && !hard_req && $stable(vec_word0)));

    a_r7_wake: assert property (@(posedge clk) disable iff (rst)
        (!busy && |irq_lvl) |=> !halted);

    a_r7_halt: assert property (@(posedge clk) disable iff (rst)
        (busy && halt_set) |=> halted);

    a_r8_prio: assert property (@(posedge clk) disable iff (rst)
        (irq_prio == (hard_req ? PRIO_VEC : '0)) && ((status_q & ~(STATUS_W'(1) << BUSY_BIT)) == '0));

    a_r1_reset: assert property (@(posedge clk)
        rst |=> (status_q == '0 && !hard_req && !halted && trap_code == '0 && vec_word0 == '0));
endmodule

bind vec_irq_latch vrl_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_lvl   (irq_lvl),
    .halt_set  (halt_set),
    .status_q  (status_q),
    .vec_word0 (vec_word0),
    .vec_word1 (vec_word1),
    .vec_word2 (vec_word2),
    .trap_code (trap_code),
    .hard_req  (hard_req),
    .irq_prio  (irq_prio),
    .halted    (halted)
);

// File: tb/sim_vec_irq_latch.sv
`timescale 1ns/1ps
module sim_vec_irq_latch;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int RAND_CYC   = 3000;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] irq_lvl;
    logic         halt_set;
    logic [7:0]   status_q;
    logic [63:0]  vec_word0, vec_word1, vec_word2;
    logic [8:0]   trap_code;
    logic         hard_req;
    logic [4:0]   irq_prio;
    logic         halted;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model
    bit        m_busy;
    int        m_line;
    logic [63:0] m_w0;
    logic [8:0]  m_trap;
    bit        m_halted;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_latch #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst(rst), .irq_lvl(irq_lvl), .halt_set(halt_set),
        .status_q(status_q), .vec_word0(vec_word0), .vec_word1(vec_word1),
        .vec_word2(vec_word2), .trap_code(trap_code), .hard_req(hard_req),
        .irq_prio(irq_prio), .halted(halted)
    );

    function automatic logic [63:0] exp_word0(input int line);
        return 64'(line) | (64'h1F << 6);
    endfunction

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) lowest = i;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [7:0] es;
        es = m_busy ? 8'h20 : 8'h00;
        chk(status_q == es, "R2/R6/R8 status", 64'(status_q), 64'(es));
        chk(hard_req == m_busy, "R2/R6 hard_req", 64'(hard_req), 64'(m_busy));
        chk(vec_word0 == m_w0, "R3/R4/R5 word0", vec_word0, m_w0);
        chk(vec_word1 == 64'h0 && vec_word2 == 64'h0, "R3 words1-2", vec_word1 | vec_word2, 64'h0);
        chk(trap_code == m_trap, "R2 trap_code", 64'(trap_code), 64'(m_trap));
        chk(halted == m_halted, "R7 halted", 64'(halted), 64'(m_halted));
        chk(irq_prio == (m_busy ? 5'd16 : 5'd0), "R8 irq_prio", 64'(irq_prio), m_busy ? 64'd16 : 64'd0);
    endtask

    // drive at negedge, advance model, check after edge
    task automatic step(input logic [N-1:0] lv, input bit hs);
        bit acc;
        @(negedge clk);
        irq_lvl  = lv;
        halt_set = hs;
        acc = 0;
        if (m_busy) begin
            if (!lv[m_line]) m_busy = 0;
        end else if (|lv) begin
            acc    = 1;
            m_busy = 1;
            m_line = lowest(lv);
            m_w0   = exp_word0(m_line);
            m_trap = 9'h060;
        end
        if (acc) m_halted = 0;
        else if (hs) m_halted = 1;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    initial begin
        int unsigned cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] lv;
        void'($urandom(32'h5EED_1234));
        rst = 1; irq_lvl = '0; halt_set = 0;
        m_busy = 0; m_line = 0; m_w0 = '0; m_trap = '0; m_halted = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(status_q == 0 && hard_req == 0 && halted == 0 && irq_prio == 0, "R1 ctrl reset",
            64'({status_q, hard_req, halted, irq_prio}), 64'h0);
        chk(vec_word0 == 0 && vec_word1 == 0 && vec_word2 == 0 && trap_code == 0, "R1 payload reset",
            vec_word0 | vec_word1 | vec_word2 | 64'(trap_code), 64'h0);
        @(negedge clk);
        rst = 0;

        // R7: halt while idle
        step('0, 1);
        // R4: lines 3 and 5 together -> 3 captured, wakes (R7)
        step(8'b0010_1000, 0);
        chk(vec_word0 == 64'h7C3, "R4 lowest line", vec_word0, 64'h7C3);
        chk(!halted, "R7 wake on capture", 64'(halted), 64'h0);
        // R5: line 1 rises while busy; payload unchanged
        step(8'b0010_1010, 0);
        chk(vec_word0 == 64'h7C3 && status_q == 8'h20, "R5 blocked while busy", vec_word0, 64'h7C3);
        // R7: halt while busy
        step(8'b0010_1010, 1);
        // R6: drop line 3, release; line 1 remains
        step(8'b0010_0010, 0);
        chk(status_q == 8'h00 && !hard_req && vec_word0 == 64'h7C3, "R6 release keeps payload",
            64'(status_q), 64'h0);
        // R5: waiting line 1 captured after free; R7 capture beats halt_set
        step(8'b0010_0010, 1);
        chk(vec_word0 == 64'h7C1 && !halted, "R5 waiting line captured", vec_word0, 64'h7C1);
        // R3: highest line alone
        step('0, 0);
        step(8'b1000_0000, 0);
        chk(vec_word0 == 64'h7C7 && trap_code == 9'h060, "R3 line 7 word0", vec_word0, 64'h7C7);
        step('0, 0);

        // random phase
        lv = '0;
        for (int c = 0; c < RAND_CYC; c++) begin
            for (int b = 0; b < N; b++) begin
                if ($urandom_range(7) == 0) lv[b] = ~lv[b];
            end
            step(lv, $urandom_range(3) == 0);
        end

        // R1 mid-run reset
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1;
        chk(status_q == 0 && vec_word0 == 0 && trap_code == 0 && !hard_req && !halted,
            "R1 reset mid-run", vec_word0, 64'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule